// File: doc/BRIEF.md
# Instruction Fetch Cycle Controller

This controller sits between the instruction-fetch port of a processor and a synchronous on-chip instruction memory with one cycle of read latency. The processor presents an address with a two-bit cycle-type code one clock before the instruction word is due. The controller sorts each bus cycle into one of four types: a fresh (non-sequential) fetch, a sequential fetch, an internal cycle or an idle cycle. It returns the 32-bit word in the following clock. If that clock cannot deliver the word, it raises a wait signal.

Fetches that continue a run of consecutive words, in the same address region, go to memory straight from the address phase and finish with no wait. A fresh fetch needs one extra cycle to decode its region. An internal cycle may carry the address of the next fetch early. The controller records that address, which pre-decodes its region, but it starts no memory access during the internal cycle. When the next cycle is a sequential fetch to that same address (a merged pair), the access launches at once with no decode wait. A sequential fetch that does not follow on from the previous one falls back to the slow path.

Top module: `ifetch_ctrl`

## Requirements
- R1: Cycle type is encoded as {cpu_mreq_n, cpu_seq}: 00 is a non-sequential fetch, 01 a sequential fetch, 10 an internal cycle, 11 idle. A non-sequential fetch always raises cpu_wait for exactly one cycle in its data phase.
- R2: An internal or idle cycle launches no memory access (mem_en low in its address phase) and causes no wait in the cycle after it.
- R3: A sequential fetch whose byte address is the previous fetch address plus 4, and which lies in the same region as that previous fetch, launches mem_en in its address phase and completes with no wait. Idle cycles between the two fetches do not break this.
- R4: A sequential fetch that immediately follows an internal cycle and carries the address broadcast in that internal cycle launches in its address phase and completes with no wait.
- R5: A sequential fetch with a wrong address (not previous plus 4, or, directly after an internal cycle, not equal to the broadcast address) is handled as non-sequential: no launch in its address phase and one wait cycle.
- R6: After reset, no prior fetch and no pre-decoded region are valid. The first fetch, of any type, takes one wait cycle. During reset, cpu_wait and mem_en are low.
- R7: cpu_rdata, sampled in the data-phase cycle where cpu_wait is low, equals the memory word at byte address bits [AW-1:2] of that fetch.
- R8: A wait lasts exactly one cycle. In that cycle the memory is accessed (mem_en high) at the waiting fetch's word address, not at the address the processor is holding for the next cycle.
- R9: The region is byte address bits [AW-1:RGN_LSB]. A sequential plus-4 fetch that crosses into a new region takes one wait cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | AW | Byte address of the address phase |
| cpu_mreq_n | input | 1 | Cycle-type bit, low for a fetch |
| cpu_seq | input | 1 | Cycle-type bit, sequential flag |
| cpu_wait | output | 1 | High while the data phase is stretched |
| cpu_rdata | output | 32 | Fetched instruction word |
| mem_en | output | 1 | Memory read strobe |
| mem_addr | output | AW-2 | Memory word address |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_en |

## Verification
The data phase of one fetch always overlaps the address phase of the next cycle. The hard case is a slow fetch whose wait cycle meets a fast sequential or merged fetch that the processor is already holding. In that cycle the memory port must serve the waiting fetch, and the held fetch must launch only on release. The bench provokes this with random streams in which fresh fetches, mismatched sequentials and region crossings run straight into follow-on fetches. In every wait cycle it checks mem_addr against the stalled fetch. In the release cycle it checks cpu_rdata against a computed memory word and mem_en against its own model of the held cycle.

// File: rtl/ifetch_ctrl.sv
module ifetch_ctrl #(
  parameter int AW      = 16,
  parameter int RGN_LSB = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_mreq_n,
  input  logic          cpu_seq,
  output logic          cpu_wait,
  output logic [31:0]   cpu_rdata,
  output logic          mem_en,
  output logic [AW-3:0] mem_addr,
  input  logic [31:0]   mem_rdata
);
  localparam int WA = AW - 2;
  localparam int RW = AW - RGN_LSB;

  logic          dp_fetch, dp_slow, dp_stage;
  logic [WA-1:0] dp_word;
  logic [AW-1:0] last_addr, bcast_addr;
  logic [RW-1:0] rgn_tag;
  logic          rgn_valid, prev_int;

  wire fetch   = !cpu_mreq_n;
  wire is_s    = !cpu_mreq_n && cpu_seq;
  wire is_i    = cpu_mreq_n && !cpu_seq;
  wire seq_ok  = (cpu_addr == last_addr + AW'(4)) && (cpu_addr[AW-1:RGN_LSB] == rgn_tag);
  wire fast    = is_s && rgn_valid && (prev_int ? (cpu_addr == bcast_addr) : seq_ok);

  assign cpu_wait  = dp_fetch && dp_slow && !dp_stage;
  assign mem_en    = cpu_wait || fast;
  assign mem_addr  = cpu_wait ? dp_word : cpu_addr[AW-1:2];
  assign cpu_rdata = mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dp_fetch   <= 1'b0;
      dp_slow    <= 1'b0;
      dp_stage   <= 1'b0;
      dp_word    <= '0;
      last_addr  <= '0;
      bcast_addr <= '0;
      rgn_tag    <= '0;
      rgn_valid  <= 1'b0;
      prev_int   <= 1'b0;
    end else if (cpu_wait) begin
      dp_stage <= 1'b1;
    end else begin
      dp_fetch <= fetch;
      dp_slow  <= !fast;
      dp_stage <= 1'b0;
      dp_word  <= cpu_addr[AW-1:2];
      prev_int <= is_i;
      if (is_i) bcast_addr <= cpu_addr;
      if (fetch) begin
        last_addr <= cpu_addr;
        rgn_tag   <= cpu_addr[AW-1:RGN_LSB];
        rgn_valid <= 1'b1;
      end
    end
  end

  // R1: a fresh fetch accepted now is stretched in its data phase
  a_r1_fresh_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_mreq_n && !cpu_seq && !cpu_wait) |=> cpu_wait);

  // R2: internal and idle cycles touch no memory and leave no wait behind
  a_r2_no_access_internal: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_mreq_n && !cpu_wait) |-> !mem_en);
  a_r2_no_wait_after: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_mreq_n && !cpu_wait) |=> !cpu_wait);

  // R3, R4: a launched address-phase fetch needs no wait
  a_r3_fast_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !cpu_wait) |=> !cpu_wait);

  // R6: nothing is fast before the first fetch after reset
  a_r6_first_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (!rgn_valid && !cpu_mreq_n && !cpu_wait) |=> cpu_wait);

  // R8: one wait cycle, serving the stalled fetch's address
  a_r8_single_wait: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wait |=> !cpu_wait);
  a_r8_wait_addr: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wait |-> (mem_en && mem_addr == $past(cpu_addr[AW-1:2])));
endmodule

// File: tb/test_ifetch_ctrl.sv
module test_ifetch_ctrl;
  localparam int AW = 16;
  localparam int RGN_LSB = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_mreq_n = 1'b1;
  logic          cpu_seq = 1'b1;
  logic          cpu_wait;
  logic [31:0]   cpu_rdata;
  logic          mem_en;
  logic [AW-3:0] mem_addr;
  logic [31:0]   mem_rdata = '0;

  int total = 0;
  int fails = 0;

  logic [AW-1:0] m_last = '0, m_bc = '0;
  logic          m_valid = 1'b0, m_pint = 1'b0;
  logic          p_fetch = 1'b0, p_slow = 1'b0;
  logic [AW-1:0] p_addr = '0;
  string         p_tag = "R2";

  ifetch_ctrl #(.AW(AW), .RGN_LSB(RGN_LSB)) i_ifetch_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_mreq_n(cpu_mreq_n),
    .cpu_seq(cpu_seq), .cpu_wait(cpu_wait), .cpu_rdata(cpu_rdata),
    .mem_en(mem_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata));

  always #5 clk = ~clk;

  function automatic logic [31:0] mdata(input logic [AW-3:0] w);
    return {w, ~w, 4'hA} ^ 32'h5A3C_0F96;
  endfunction

  always @(posedge clk) if (mem_en) mem_rdata <= mdata(mem_addr);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] t, input logic [AW-1:0] a);
    logic fetch, fast;
    string tag;
    @(negedge clk);
    cpu_mreq_n = t[1];
    cpu_seq    = t[0];
    cpu_addr   = a;
    #1;
    fetch = !t[1];
    fast  = 1'b0;
    tag   = "R2";
    if (fetch) begin
      if (!m_valid) tag = "R6";
      else if (!t[0]) tag = "R1";
      else if (m_pint) begin
        fast = (a == m_bc);
        tag  = fast ? "R4" : "R5";
      end else if (a == m_last + 16'd4) begin
        fast = (a[AW-1:RGN_LSB] == m_last[AW-1:RGN_LSB]);
        tag  = fast ? "R3" : "R9";
      end else tag = "R5";
    end
    if (p_fetch && p_slow) begin
      chk(cpu_wait == 1'b1, p_tag, 32'(cpu_wait), 32'd1);
      chk(mem_en && mem_addr == p_addr[AW-1:2], "R8", 32'(mem_addr), 32'(p_addr[AW-1:2]));
      @(negedge clk); #1;
      chk(cpu_wait == 1'b0, "R8", 32'(cpu_wait), 32'd0);
    end else begin
      chk(cpu_wait == 1'b0, p_fetch ? p_tag : "R2", 32'(cpu_wait), 32'd0);
    end
    if (p_fetch) chk(cpu_rdata == mdata(p_addr[AW-1:2]), "R7", cpu_rdata, mdata(p_addr[AW-1:2]));
    if (!fetch) chk(mem_en == 1'b0, "R2", 32'(mem_en), 32'd0);
    else chk(mem_en == fast, tag, 32'(mem_en), 32'(fast));
    if (fetch) begin m_last = a; m_valid = 1'b1; end
    m_pint = (t == 2'b10);
    if (t == 2'b10) m_bc = a;
    p_fetch = fetch;
    p_slow  = !fast;
    p_addr  = a;
    p_tag   = tag;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL R8: watchdog expired, actual hung expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(42));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cpu_wait == 1'b0 && mem_en == 1'b0, "R6", {cpu_wait, mem_en}, 32'd0);
    rst_n = 1'b1;
    // directed corner cases
    step(2'b10, 16'h0040);  // internal with broadcast
    step(2'b01, 16'h0040);  // merged but first after reset: R6 slow
    step(2'b01, 16'h0044);  // R3 fast
    step(2'b01, 16'h004C);  // R5 skipped word
    step(2'b10, 16'h0080);
    step(2'b01, 16'h0084);  // R5 merged mismatch
    step(2'b10, 16'h0090);
    step(2'b01, 16'h0090);  // R4 merged fast
    step(2'b00, 16'h03FC);  // R1
    step(2'b01, 16'h0400);  // R9 region crossing
    step(2'b11, 16'h1234);  // idle
    step(2'b01, 16'h0404);  // R3 across idle
    step(2'b00, 16'h2000);  // R1 then fast run into R8 overlap
    step(2'b01, 16'h2004);
    step(2'b10, 16'h2008);
    step(2'b01, 16'h2008);
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [1:0] t;
      logic [AW-1:0] a;
      r = int'($urandom % 10);
      t = (r < 2) ? 2'b00 : (r < 7) ? 2'b01 : (r < 9) ? 2'b10 : 2'b11;
      a = AW'($urandom) & 16'hFFFC;
      if (t == 2'b01) begin
        if (m_pint && ($urandom % 4) != 0) a = m_bc;
        else if (($urandom % 5) != 0) a = m_last + 16'd4;
      end else if (t == 2'b10 && ($urandom % 3) != 0) a = m_last + 16'd4;
      step(t, a);
    end
    step(2'b11, 16'h0000);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule